// File: doc/BRIEF.md
# Latched Address Inverting Line Decoder

This block turns a 4-bit binary address into one of 16 active-low select lines. A level-sensitive holding latch sits in front of the decoder. While the load input is high, the latch is transparent, so the select vector follows the live address. When the load input goes low, the latch keeps the last address it saw. A separate active-low gate input decides whether the selected line is pulled low at all. When the gate is high, every line stays high.

The gate input does not touch the latch. This lets the block act as a 1-to-16 demultiplexer: the latch holds a destination, a serial data value is driven onto the gate, and the addressed line carries that value while the other fifteen lines stay high. An optional clocked clear forces the held address to zero without changing how the gate acts on the outputs.

Top module: `latched_line_decoder`

## Requirements
- R1: While `latchEn` is 1, `enN` is 0 and no clear is active, `selN` equals all ones with only bit `addrIn` at 0. `addrIn` bit 0 is the least significant bit.
- R2: At no time is more than one bit of `selN` at 0.
- R3: While `latchEn` is 0, `selN` reflects the address present when `latchEn` fell. Later changes on `addrIn` have no effect on `selN`.
- R4: While `enN` is 1, all 16 bits of `selN` are 1, whatever the address or latch state.
- R5: Changing `enN` never alters the held address. After any number of `enN` toggles with the latch closed, taking `enN` low again selects the same line as before.
- R6: In demultiplexer use, with the latch closed on address k, `selN[k]` equals `enN` and every other bit of `selN` is 1.
- R7: When `rst` is 1 at a rising `clk` edge, from that edge until the first edge at which `rst` is sampled 0, the held address is forced to 0, overriding `latchEn`. After the clear ends, the address stays 0 until `latchEn` loads a new one.
- R8: The clear does not bypass the gate. With the clear active and `enN` at 1, all bits of `selN` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the clear request |
| rst | input | 1 | Synchronous clear request for the held address, active high |
| addrIn | input | 4 | Binary line address, bit 0 least significant |
| latchEn | input | 1 | Latch transparent when 1, holding when 0 |
| enN | input | 1 | Active-low output gate; data input in demultiplexer use |
| selN | output | 16 | Active-low one-cold select vector |

## Verification
The only internal state is the held address and the registered clear flag, so any corruption shows on `selN` in the same cycle. If the gate is open, the wrong line goes low. If the held address is corrupted while the latch is closed, the output moves with no input change. The bench closes the latch on each address and then changes the address and toggles the gate, so a latch that leaks or is disturbed by the gate is caught at the first compare after the stimulus. A clear that lasts too long or too short shows up in the cycle right after `rst` drops.

// File: rtl/lad_pkg.sv
package lad_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;   // latch transparent
    logic clear;  // force held address to zero
    logic gate;   // drive the selected line low
  } ladStrb_t;
endpackage

// File: rtl/lad_ctrl.sv
module lad_ctrl
  import lad_pkg::*;
#(
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     latchEn,
  input  logic     enN,
  output ladStrb_t strb
);

  logic clrQ;

  generate
    if (SYNC_CLR) begin : g_clr
      // clear request sampled on the clock edge
      always_ff @(posedge clk) begin
        clrQ <= rst;
      end
    end else begin : g_noclr
      assign clrQ = 1'b0;
    end
  endgenerate

  always_comb begin
    strb.load  = latchEn;
    strb.clear = clrQ;
    strb.gate  = ~enN;
  end

endmodule

// File: rtl/lad_path.sv
module lad_path
  import lad_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int OUT_N  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addrIn,
  input  ladStrb_t          strb,
  output logic [OUT_N-1:0]  selN
);

  logic [ADDR_W-1:0] held;

  // level-sensitive holding latch, clear has priority
  always_latch begin
    if (strb.clear)
      held = '0;
    else if (strb.load)
      held = addrIn;
  end

  genvar i;
  generate
    for (i = 0; i < OUT_N; i++) begin : g_line
      assign selN[i] = ~(strb.gate && (held == ADDR_W'(i)));
    end
  endgenerate

endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder
  import lad_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int OUT_N    = 1 << ADDR_W,
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              latchEn,
  input  logic              enN,
  output logic [OUT_N-1:0]  selN
);

  ladStrb_t ctrlStrb;

  lad_ctrl #(.SYNC_CLR(SYNC_CLR)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .latchEn(latchEn),
    .enN    (enN),
    .strb   (ctrlStrb)
  );

  lad_path #(.ADDR_W(ADDR_W), .OUT_N(OUT_N)) u_path (
    .addrIn(addrIn),
    .strb  (ctrlStrb),
    .selN  (selN)
  );

endmodule

// File: rtl/lld_checker.sv
module lld_checker #(
  parameter int ADDR_W = 4,
  parameter int OUT_N  = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addrIn,
  input logic              latchEn,
  input logic              enN,
  input logic [OUT_N-1:0]  selN,
  input logic              clrAct
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_AT_MOST_ONE_LOW: assert property (@(posedge clk) disable iff (rst)
    $countones(~selN) <= 1); // R2

  AST_OPEN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (latchEn && !enN && !clrAct) |-> (selN == ~(OUT_N'(1) << addrIn))); // R1

  AST_GATE_HIGH: assert property (@(posedge clk) disable iff (rst)
    enN |-> (&selN)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (armed && !latchEn && $past(!latchEn) && !clrAct && !$past(clrAct)
     && $stable(enN)) |-> $stable(selN)); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clrAct && !enN) |-> (selN == ~OUT_N'(1))); // R7

  AST_CLEAR_GATED: assert property (@(posedge clk) disable iff (rst)
    (clrAct && enN) |-> (&selN)); // R8

endmodule

bind latched_line_decoder lld_checker #(.ADDR_W(ADDR_W), .OUT_N(OUT_N)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .addrIn (addrIn),
  .latchEn(latchEn),
  .enN    (enN),
  .selN   (selN),
  .clrAct (ctrlStrb.clear)
);

// File: tb/latched_line_decoder_bench.sv
module latched_line_decoder_bench;

  localparam int AW = 4;
  localparam int ON = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addrIn;
  logic          latchEn;
  logic          enN;
  logic [ON-1:0] selN;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  latched_line_decoder u_latched_line_decoder (
    .clk(clk), .rst(rst), .addrIn(addrIn),
    .latchEn(latchEn), .enN(enN), .selN(selN)
  );

  function automatic logic [ON-1:0] oneCold(int a);
    return 16'hFFFF ^ (16'h0001 << a);
  endfunction

  task automatic chk(string tag, logic [ON-1:0] act, logic [ON-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    rst = 1'b1; latchEn = 1'b1; enN = 1'b0; addrIn = 4'd5;
    repeat (3) @(posedge clk);
    step(); settle();
    chk("R7 clear overrides open latch", selN, 16'hFFFE);
    enN = 1'b1; settle();
    chk("R8 clear with gate high", selN, 16'hFFFF);
    enN = 1'b0;

    // close latch, drop reset; clear ends at next edge
    step(); rst = 1'b0; latchEn = 1'b0; addrIn = 4'd9;
    step(); step(); settle();
    chk("R7 held zero after clear", selN, 16'hFFFE);

    // transparent sweep
    for (int a = 0; a < ON; a++) begin
      step(); latchEn = 1'b1; addrIn = AW'(a); settle();
      chk("R1 transparent decode", selN, oneCold(a));
      nChk++;
      if ($countones(~selN) > 1) begin
        nBad++;
        $display("FAIL R2 lows actual=%0d expected<=1", $countones(~selN));
      end
    end

    // hold, gate toggles, demux
    for (int a = 0; a < ON; a++) begin
      step(); latchEn = 1'b1; addrIn = AW'(a); enN = 1'b0;
      step(); latchEn = 1'b0;
      step(); addrIn = AW'((a + 7) % ON); settle();
      chk("R3 held across address change", selN, oneCold(a));
      step(); enN = 1'b1; addrIn = AW'((a + 3) % ON); settle();
      chk("R4 gate high all lines high", selN, 16'hFFFF);
      step(); enN = 1'b0; settle();
      chk("R5 held address after gate toggle", selN, oneCold(a));
      for (int b = 0; b < 4; b++) begin
        step(); enN = ((a >> b) & 1) != 0; settle();
        chk("R6 demux line carries data", selN,
            enN ? 16'hFFFF : oneCold(a));
      end
    end

    // R4 with open latch
    step(); latchEn = 1'b1; enN = 1'b1; addrIn = 4'd12; settle();
    chk("R4 gate high open latch", selN, 16'hFFFF);

    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule